// File: doc/BRIEF.md
# Collision Indication and Heartbeat Generator

This block drives the single collision/control line that a half-duplex 10 Mb/s twisted-pair port presents to its media access controller. While the port transmits, the line goes high whenever the receive side reports qualified activity, which means another station is talking at the same time. The line is forced low for collisions in two cases: full-duplex operation, where both directions run at once by design, and loopback, where the receive path only carries the port's own transmit data.

When a transmission ends, the same line carries a heartbeat. After a fixed gap measured in bit times, it gives one pulse of fixed length. The controller uses this pulse to confirm that collision signalling works. The heartbeat is not sent in three cases: the active-low test enable is high when transmission ends, the transmission was cut short by the jabber guard, or a new transmission starts before the pulse has finished.

All pins are plain level-sensitive control signals sampled on the rising clock edge. No data stream crosses the block, so it has no valid/ready handshake and no back-pressure. Bit time is `BIT_CYCLES` clocks, which is 100 ns of real time in the target system.

Top module: `csq_collision_sqe`

## Requirements
- R1: While reset is asserted and on the first cycles after reset is released with all inputs idle, `coll_ctl` is 0.
- R2: With `fdx_n` = 1 and `loop_n` = 1, `coll_ctl` is 1 one clock after a rising edge that samples `tx_en` = 1 and `rx_valid` = 1. It stays 1 for every such sample.
- R3: A sample with `tx_en` = 0 or `rx_valid` = 0 shows no collision: with no heartbeat pending, `coll_ctl` is 0 one clock later.
- R4: While `fdx_n` = 0 (full duplex), concurrent `tx_en` and `rx_valid` never raise `coll_ctl`.
- R5: While `loop_n` = 0 (loopback), concurrent `tx_en` and `rx_valid` never raise `coll_ctl`.
- R6: Let edge E0 be the first rising edge that samples `tx_en` = 0 after it was 1. If `sqe_en_n` = 0 at E0, `coll_ctl` is 1 after edges E0+D through E0+D+L-1 and 0 otherwise. Here D = `SQE_GAP_BITS`·`BIT_CYCLES` and L = `SQE_WIDTH_BITS`·`BIT_CYCLES`, and the gap is between 6 and 16 bit times.
- R7: If `sqe_en_n` = 1 at E0, no heartbeat follows that transmission.
- R8: A sample of `tx_en` = 1 while a heartbeat is waiting or in progress cancels it. `coll_ctl` shows no heartbeat from the next clock on.
- R9: If `jabber` was 1 on any sample from the transmission's first cycle through E0, no heartbeat follows that transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `BIT_CYCLES` cycles per bit time |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter active |
| rx_valid | input | 1 | Receive squelch open (qualified activity) |
| sqe_en_n | input | 1 | Heartbeat enable, active low |
| fdx_n | input | 1 | Full-duplex select, active low |
| loop_n | input | 1 | Loopback select, active low |
| jabber | input | 1 | Jabber guard has cut the transmission |
| coll_ctl | output | 1 | Collision indication OR heartbeat pulse |

## Verification
A collision appears on `coll_ctl` exactly one clock after the edge that samples it. A heartbeat rises exactly D clocks after the edge that first samples `tx_en` low and holds for L clocks. A cancelling `tx_en` clears the line one clock after it is sampled. The driver samples each stimulus cycle on its rising edge and, for that cycle, queues the value the line must show after that edge. The monitor compares it at the next falling edge, so every check lands on the cycle in which the result is due and never on an edge.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WAIT  = 2'd1,
    SQ_BURST = 2'd2
  } sq_state_t;
endpackage

// File: rtl/csq_coll_detect.sv
module csq_coll_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic rx_valid,
  input  logic fdx_n,
  input  logic loop_n,
  output logic coll_q
);
  // Half-duplex, non-loopback overlap of transmit and receive
  logic overlap;
  assign overlap = tx_en & rx_valid & fdx_n & loop_n;

  always_ff @(posedge clk) begin
    if (!rst_n) coll_q <= 1'b0;
    else        coll_q <= overlap;
  end

  assert_coll_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && rx_valid && fdx_n && loop_n) |=> coll_q);
  assert_coll_needs_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && rx_valid) |=> !coll_q);
  assert_fdx_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fdx_n |=> !coll_q);
  assert_loop_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_n |=> !coll_q);
endmodule

// File: rtl/csq_sqe_timer.sv
module csq_sqe_timer
  import csq_pkg::*;
#(
  parameter int DLY_CYC = 40,
  parameter int LEN_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic sqe_en_n,
  input  logic jabber,
  output logic sqe_pulse
);
  localparam int MAXC = (DLY_CYC > LEN_CYC) ? DLY_CYC : LEN_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(DLY_CYC - 1);
  localparam logic [CW-1:0] LEN_LAST = CW'(LEN_CYC - 1);

  sq_state_t      state;
  logic [CW-1:0]  cnt;
  logic           tx_d;
  logic           jab_seen;
  logic           tx_rise, tx_fall, jab_now, arm;

  assign tx_rise = tx_en & ~tx_d;
  assign tx_fall = tx_d & ~tx_en;
  assign jab_now = jab_seen | jabber;
  assign arm     = tx_fall & ~sqe_en_n & ~jab_now;

  // Transmit history and sticky jabber flag for the current transmission
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_d     <= 1'b0;
      jab_seen <= 1'b0;
    end else begin
      tx_d <= tx_en;
      if (tx_rise)     jab_seen <= jabber;
      else if (tx_en)  jab_seen <= jab_now;
    end
  end

  // Gap then pulse, cancelled by any new transmission
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (arm) begin
            state <= SQ_WAIT;
            cnt   <= '0;
          end
        end
        SQ_WAIT: begin
          if (tx_en) begin
            state <= SQ_IDLE;
          end else if (cnt == DLY_LAST) begin
            state <= SQ_BURST;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_BURST: begin
          if (tx_en || cnt == LEN_LAST) begin
            state <= SQ_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign sqe_pulse = (state == SQ_BURST);

  assert_cancel_on_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> (state == SQ_IDLE));
  assert_muted_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fall && sqe_en_n) |=> (state == SQ_IDLE));
  assert_jabber_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fall && jab_now) |=> (state == SQ_IDLE));
  assert_gap_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_WAIT) |-> (cnt < CW'(DLY_CYC)));
  assert_burst_after_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_BURST && $past(state) != SQ_BURST) |-> ($past(state) == SQ_WAIT));
endmodule

// File: rtl/csq_collision_sqe.sv
module csq_collision_sqe #(
  parameter int BIT_CYCLES     = 4,
  parameter int SQE_GAP_BITS   = 10,
  parameter int SQE_WIDTH_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic rx_valid,
  input  logic sqe_en_n,
  input  logic fdx_n,
  input  logic loop_n,
  input  logic jabber,
  output logic coll_ctl
);
  localparam int GAP_CYC = SQE_GAP_BITS * BIT_CYCLES;
  localparam int LEN_CYC = SQE_WIDTH_BITS * BIT_CYCLES;

  logic coll_q;
  logic sqe_pulse;

  csq_coll_detect u_coll (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .rx_valid (rx_valid),
    .fdx_n    (fdx_n),
    .loop_n   (loop_n),
    .coll_q   (coll_q)
  );

  csq_sqe_timer #(
    .DLY_CYC (GAP_CYC),
    .LEN_CYC (LEN_CYC)
  ) u_sqe (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .sqe_en_n  (sqe_en_n),
    .jabber    (jabber),
    .sqe_pulse (sqe_pulse)
  );

  assign coll_ctl = coll_q | sqe_pulse;

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> !sqe_pulse);
  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> !coll_ctl);
endmodule

// File: tb/test_csq_collision_sqe.sv
module test_csq_collision_sqe;
  localparam int BITC = 4;
  localparam int DLY  = 10 * BITC;
  localparam int LEN  = 10 * BITC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, rx_valid = 1'b0, sqe_en_n = 1'b1;
  logic fdx_n = 1'b1, loop_n = 1'b1, jabber = 1'b0;
  logic coll_ctl;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit q_exp[$];
  string q_tag[$];

  always #2 clk = ~clk;

  csq_collision_sqe #(.BIT_CYCLES(BITC), .SQE_GAP_BITS(10), .SQE_WIDTH_BITS(10)) i_csq_collision_sqe (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_valid(rx_valid),
    .sqe_en_n(sqe_en_n), .fdx_n(fdx_n), .loop_n(loop_n), .jabber(jabber),
    .coll_ctl(coll_ctl)
  );

  // Monitor: compares the queued value for the edge just passed
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      bit e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_checks++;
      if (coll_ctl !== e) begin
        n_fail++;
        $display("FAIL %s: coll_ctl=%b expected=%b at %0t", t, coll_ctl, e, $time);
      end
    end
  end

  // Driver: one cycle of stimulus plus the value due after its sampling edge
  task automatic cyc(input logic t, input logic r, input bit e, input string tag);
    @(negedge clk);
    tx_en = t;
    rx_valid = r;
    @(posedge clk);
    #1;
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic burst_tx(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, tag);
  endtask

  // Idle cycles after a transmission; j = 0 is the first edge sampling tx_en low
  task automatic tail(input bit pulse, input int n, input string tag);
    for (int j = 0; j < n; j++)
      cyc(1'b0, 1'b0, pulse && j >= DLY && j < DLY + LEN, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if (coll_ctl !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: coll_ctl=%b expected=0 during reset", coll_ctl);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, "R1");

    // Collisions with heartbeat disabled
    cyc(1'b1, 1'b0, 1'b0, "R3");
    cyc(1'b1, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b1, "R2");
    cyc(1'b1, 1'b0, 1'b0, "R3");
    cyc(1'b1, 1'b1, 1'b1, "R2");
    cyc(1'b0, 1'b1, 1'b0, "R3");
    tail(1'b0, DLY + LEN + 4, "R7");

    // Full duplex
    fdx_n = 1'b0;
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 1'b0, "R4");
    cyc(1'b0, 1'b0, 1'b0, "R4");
    fdx_n = 1'b1;

    // Loopback
    loop_n = 1'b0;
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 1'b0, "R5");
    cyc(1'b0, 1'b0, 1'b0, "R5");
    loop_n = 1'b1;

    // Heartbeat timing
    sqe_en_n = 1'b0;
    burst_tx(5, "R6");
    tail(1'b1, DLY + LEN + 5, "R6");

    // Collision followed by heartbeat
    burst_tx(2, "R6");
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1, "R2");
    tail(1'b1, DLY + LEN + 3, "R6");

    // Cancel during the gap
    burst_tx(3, "R8");
    tail(1'b1, 10, "R8");
    burst_tx(3, "R8");
    tail(1'b1, DLY + LEN + 3, "R6");

    // Cancel during the pulse
    burst_tx(3, "R8");
    tail(1'b1, DLY + 5, "R6");
    burst_tx(2, "R8");
    tail(1'b1, DLY + LEN + 3, "R6");

    // Jabber-cut transmission
    burst_tx(3, "R9");
    jabber = 1'b1;
    burst_tx(2, "R9");
    jabber = 1'b0;
    burst_tx(3, "R9");
    tail(1'b0, DLY + LEN + 4, "R9");

    // Next clean transmission recovers
    burst_tx(4, "R9");
    tail(1'b1, DLY + LEN + 3, "R9");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule